// File: doc/BRIEF.md
# Microprocessor bus state capture

This block watches the parallel bus of an 8-bit microprocessor and records it in state mode. That means one record per finished bus transaction, not one per system clock. The bus pins come in asynchronously: a 16-bit address, an 8-bit data byte and nine active-low strobes. The strobes are memory request, I/O request, write, refresh, opcode fetch, bus request, halt, interrupt and NMI. All of them are synchronised into the system clock domain, and every strobe edge is found there.

Three capture clocks are derived from the strobes:
- a memory clock, which is the inverted memory request;
- an I/O clock, which is the inverted I/O request;
- a refresh level, which is the refresh strobe as it arrives.

A capture event is an edge on the memory clock or the I/O clock. A configuration bit can make the event count only while the refresh level is high, so refresh cycles are dropped. For each event an 8-bit status byte is formed. Its write and I/O bits come from the sample taken just before the edge, because on the real bus those pins switch together with the strobes.

Software arms the unit with a one-cycle pulse. After that, nothing is stored until an event matches the trigger: an address value under a mask, and optionally a status value under a mask. From the trigger on, one 32-bit word per event is written into an internal memory. Writing stops when the post-trigger count is reached or the memory is full. The stored words are read back through a synchronous read port.

Top module: `bus_state_capture`

## Requirements
- R1: After reset, `armed`, `triggered` and `done` are 0 and `wr_count` is 0.
- R2: With `cfg_rising_edge` = 0, an event occurs when `mreq_n` or `iorq_n` goes from low to high, which is the end of the cycle. The assertion of a strobe creates no event.
- R3: With `cfg_rising_edge` = 1, an event occurs when `mreq_n` or `iorq_n` goes from high to low. The word is therefore stored while the strobe is still asserted.
- R4: With `cfg_skip_refresh` = 1, an event is discarded when `rfsh_n` is low at the moment the edge is seen. With `cfg_skip_refresh` = 0, such an event is stored.
- R5: The status byte is laid out as follows:
  - bit 0: the inverse of `wr_n`
  - bit 1: `iorq_n`
  - bit 2: `rfsh_n`
  - bit 3: `m1_n`
  - bit 4: `busreq_n`
  - bit 5: `nmi_n`
  - bit 6: `halt_n`
  - bit 7: `int_n`
- R6: Status bits 0 and 1, the address and the data are taken from the synchronised sample one clock older than the edge. Status bits 2 to 7 are taken at the edge. Two consequences follow:
  - a write strobe released together with the bus strobe still records bit 0 = 1;
  - an I/O cycle ending on `iorq_n` rising records bit 1 = 0.
- R7: A stored word is {address[31:16], data[15:8], status[7:0]}.
- R8: After `arm`, no event is stored until the trigger matches: ((address XOR `trig_addr`) AND `trig_addr_mask`) = 0. The matching event is the first stored word, at index 0. Discarded events never trigger.
- R9: With `cfg_use_status` = 1, the trigger also requires ((status XOR `trig_stat`) AND `trig_stat_mask`) = 0.
- R10: Storing stops and `done` goes to 1 once `wr_count` reaches `post_count`. A `post_count` of 0 means the full depth of 256 words. Events after `done` do not change `wr_count`.
- R11: An `arm` pulse clears `wr_count` to 0, sets `armed` and clears `triggered` and `done`.
- R12: `rd_data` holds the word at index `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Snooped address bus |
| bus_data | input | 8 | Snooped data bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| busreq_n | input | 1 | Bus request, active low |
| halt_n | input | 1 | Halt, active low |
| int_n | input | 1 | Interrupt request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active low |
| cfg_rising_edge | input | 1 | 1: capture on strobe assertion instead of release |
| cfg_skip_refresh | input | 1 | 1: discard events taken while refresh is active |
| cfg_use_status | input | 1 | 1: the trigger also compares the status byte |
| trig_addr | input | 16 | Trigger address value |
| trig_addr_mask | input | 16 | Trigger address compare mask |
| trig_stat | input | 8 | Trigger status value |
| trig_stat_mask | input | 8 | Trigger status compare mask |
| post_count | input | 9 | Words to store from the trigger on; 0 means full depth |
| arm | input | 1 | One-cycle arm pulse |
| armed | output | 1 | Waiting for the trigger |
| triggered | output | 1 | Trigger seen; storing or finished |
| done | output | 1 | Storing finished |
| wr_count | output | 9 | Number of words stored |
| rd_addr | input | 8 | Read index |
| rd_data | output | 32 | Word at the read index |

## Verification
An input edge reaches the second synchroniser flop after two clocks. The event register takes it on the third clock, and the memory write and the `wr_count` update land on the fourth. The bench therefore holds every strobe level for at least six clocks and idles at least six clocks after each release before it samples the count. The one check made during the hold compares `wr_count` with its value before the cycle: it must be unchanged in release mode and one higher in assertion mode. Read-back applies `rd_addr` at a falling edge and samples `rd_data` at the next falling edge, after the single registered read stage.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int STAT_W  = 8;
  localparam int WORD_W  = ADDR_W + DATA_W + STAT_W;
  localparam int STRB_W  = 9;
  localparam int BUS_W   = ADDR_W + DATA_W;

  // strobe vector positions
  localparam int S_MREQ   = 0;
  localparam int S_IORQ   = 1;
  localparam int S_WR     = 2;
  localparam int S_RFSH   = 3;
  localparam int S_M1     = 4;
  localparam int S_BUSREQ = 5;
  localparam int S_HALT   = 6;
  localparam int S_INT    = 7;
  localparam int S_NMI    = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [STAT_W-1:0] stat;
  } cap_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAPT, ST_DONE} cap_state_t;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  // two synchroniser flops, then one extra stage that holds the prior sample
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      cur  <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      meta <= din;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/bsc_event.sv
module bsc_event
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rising_edge,
  input  logic              cfg_skip_refresh,
  input  logic [STRB_W-1:0] strb_cur,
  input  logic [STRB_W-1:0] strb_prev,
  input  logic [BUS_W-1:0]  bus_prev,
  output logic              ev_valid,
  output cap_word_t         ev_word
);
  logic clk_j_cur, clk_j_prev, clk_k_cur, clk_k_prev, lvl_l;
  logic j_edge, k_edge, accept;
  logic [STAT_W-1:0] stat;

  always_comb begin
    clk_j_cur  = ~strb_cur[S_MREQ];
    clk_j_prev = ~strb_prev[S_MREQ];
    clk_k_cur  = ~strb_cur[S_IORQ];
    clk_k_prev = ~strb_prev[S_IORQ];
    lvl_l      = strb_cur[S_RFSH];
    if (cfg_rising_edge) begin
      j_edge = clk_j_cur & ~clk_j_prev;
      k_edge = clk_k_cur & ~clk_k_prev;
    end else begin
      j_edge = ~clk_j_cur & clk_j_prev;
      k_edge = ~clk_k_cur & clk_k_prev;
    end
    accept = (j_edge | k_edge) & (~cfg_skip_refresh | lvl_l);
    // write and io bits come from the older sample, the rest from the edge sample
    stat = {strb_cur[S_INT], strb_cur[S_HALT], strb_cur[S_NMI], strb_cur[S_BUSREQ],
            strb_cur[S_M1], strb_cur[S_RFSH], strb_prev[S_IORQ], ~strb_prev[S_WR]};
  end

  logic unused_prev;
  assign unused_prev = ^{strb_prev[S_NMI:S_RFSH], strb_cur[S_WR]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_word  <= '0;
    end else begin
      ev_valid <= accept;
      if (accept) ev_word <= {bus_prev, stat};
    end
  end

  // R4: with filtering on, no stored event carries an active refresh bit
  a_r4_refresh_excluded: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && $past(cfg_skip_refresh)) |-> ev_word.stat[2]);
endmodule

// File: rtl/bsc_trigger.sv
module bsc_trigger
  import bsc_pkg::*;
(
  input  cap_word_t         ev_word,
  input  logic              cfg_use_status,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic [ADDR_W-1:0] trig_addr_mask,
  input  logic [STAT_W-1:0] trig_stat,
  input  logic [STAT_W-1:0] trig_stat_mask,
  output logic              hit
);
  logic addr_ok, stat_ok;

  always_comb begin
    addr_ok = ((ev_word.addr ^ trig_addr) & trig_addr_mask) == '0;
    stat_ok = ((ev_word.stat ^ trig_stat) & trig_stat_mask) == '0;
    hit     = addr_ok & (~cfg_use_status | stat_ok);
  end
endmodule

// File: rtl/bsc_store.sv
module bsc_store
  import bsc_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     arm,
  input  logic                     ev_valid,
  input  logic [WORD_W-1:0]        ev_word,
  input  logic                     hit,
  input  logic [$clog2(DEPTH):0]   post_count,
  output logic                     armed,
  output logic                     triggered,
  output logic                     done,
  output logic [$clog2(DEPTH):0]   wr_count,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WORD_W-1:0]        rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  cap_state_t      state;
  logic [CW-1:0]   limit;
  logic [CW-1:0]   cnt_nx;
  logic            wr_en;
  logic [WORD_W-1:0] mem [DEPTH];

  always_comb begin
    limit  = (post_count == '0 || post_count > DEPTH_C) ? DEPTH_C : post_count;
    cnt_nx = wr_count + 1'b1;
    wr_en  = ev_valid && !arm && ((state == ST_WAIT && hit) || state == ST_CAPT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_count <= '0;
    end else if (arm) begin
      state    <= ST_WAIT;
      wr_count <= '0;
    end else if (wr_en) begin
      wr_count <= cnt_nx;
      state    <= (cnt_nx >= limit) ? ST_DONE : ST_CAPT;
    end
  end

  // storage without reset so that a block RAM can hold it
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_count[AW-1:0]] <= ev_word;
    rd_data <= mem[rd_addr];
  end

  always_comb begin
    armed     = (state == ST_WAIT);
    triggered = (state == ST_CAPT) || (state == ST_DONE);
    done      = (state == ST_DONE);
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    wr_count <= DEPTH_C);
  a_r10_frozen_when_done: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> $stable(wr_count));
  a_r8_trigger_is_first_word: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered) |-> (wr_count == 1));
  a_r11_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm |=> (wr_count == 0 && armed && !done));
  a_r8_nothing_before_arm: assert property (@(posedge clk) disable iff (rst)
    (!armed && !triggered && !arm) |=> $stable(wr_count));
endmodule

// File: rtl/bus_state_capture.sv
module bus_state_capture
  import bsc_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              bus_addr,
  input  logic [7:0]               bus_data,
  input  logic                     mreq_n,
  input  logic                     iorq_n,
  input  logic                     wr_n,
  input  logic                     rfsh_n,
  input  logic                     m1_n,
  input  logic                     busreq_n,
  input  logic                     halt_n,
  input  logic                     int_n,
  input  logic                     nmi_n,
  input  logic                     cfg_rising_edge,
  input  logic                     cfg_skip_refresh,
  input  logic                     cfg_use_status,
  input  logic [15:0]              trig_addr,
  input  logic [15:0]              trig_addr_mask,
  input  logic [7:0]               trig_stat,
  input  logic [7:0]               trig_stat_mask,
  input  logic [$clog2(DEPTH):0]   post_count,
  input  logic                     arm,
  output logic                     armed,
  output logic                     triggered,
  output logic                     done,
  output logic [$clog2(DEPTH):0]   wr_count,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [31:0]              rd_data
);
  logic [STRB_W-1:0] strb_in, strb_cur, strb_prev;
  logic [BUS_W-1:0]  bus_in, bus_cur, bus_prev;
  logic              ev_valid, hit;
  cap_word_t         ev_word;

  always_comb begin
    strb_in           = '1;
    strb_in[S_MREQ]   = mreq_n;
    strb_in[S_IORQ]   = iorq_n;
    strb_in[S_WR]     = wr_n;
    strb_in[S_RFSH]   = rfsh_n;
    strb_in[S_M1]     = m1_n;
    strb_in[S_BUSREQ] = busreq_n;
    strb_in[S_HALT]   = halt_n;
    strb_in[S_INT]    = int_n;
    strb_in[S_NMI]    = nmi_n;
    bus_in            = {bus_addr, bus_data};
  end

  bsc_sync #(.W(STRB_W), .RST_VAL({STRB_W{1'b1}})) strb_sync_i (
    .clk(clk), .rst(rst), .din(strb_in), .cur(strb_cur), .prev(strb_prev));

  bsc_sync #(.W(BUS_W), .RST_VAL('0)) bus_sync_i (
    .clk(clk), .rst(rst), .din(bus_in), .cur(bus_cur), .prev(bus_prev));

  logic unused_bus;
  assign unused_bus = ^bus_cur;

  bsc_event event_i (
    .clk(clk), .rst(rst),
    .cfg_rising_edge(cfg_rising_edge), .cfg_skip_refresh(cfg_skip_refresh),
    .strb_cur(strb_cur), .strb_prev(strb_prev), .bus_prev(bus_prev),
    .ev_valid(ev_valid), .ev_word(ev_word));

  bsc_trigger trigger_i (
    .ev_word(ev_word), .cfg_use_status(cfg_use_status),
    .trig_addr(trig_addr), .trig_addr_mask(trig_addr_mask),
    .trig_stat(trig_stat), .trig_stat_mask(trig_stat_mask), .hit(hit));

  bsc_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .arm(arm), .ev_valid(ev_valid), .ev_word(ev_word),
    .hit(hit), .post_count(post_count), .armed(armed), .triggered(triggered),
    .done(done), .wr_count(wr_count), .rd_addr(rd_addr), .rd_data(rd_data));

  // R2: in release mode an event can only follow a strobe that was active one sample earlier
  a_r2_release_needs_active: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !$past(cfg_rising_edge)) |-> ($past(strb_prev[S_MREQ], 1) == 1'b0 ||
                                               $past(strb_prev[S_IORQ], 1) == 1'b0));
endmodule

// File: tb/bus_state_capture_tb.sv
module bus_state_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  // {kind[27:24], addr[23:8], data[7:0]}
  // kind: 0 fetch, 1 mem read, 2 mem write, 3 io read, 4 io write, 5 refresh
  localparam logic [27:0] TBL [11] = '{
    {4'd0, 16'h0000, 8'h3E}, {4'd1, 16'h0050, 8'h11}, {4'd5, 16'h0100, 8'h00},
    {4'd0, 16'h0100, 8'hC3}, {4'd4, 16'h0042, 8'h55}, {4'd5, 16'h0007, 8'h00},
    {4'd2, 16'h8000, 8'hAA}, {4'd3, 16'h0011, 8'h7F}, {4'd1, 16'hFFFF, 8'h01},
    {4'd0, 16'h0101, 8'h21}, {4'd2, 16'h2222, 8'h99}};

  logic clk = 0, rst = 1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic mreq_n = 1, iorq_n = 1, wr_n = 1, rfsh_n = 1, m1_n = 1;
  logic busreq_n = 1, halt_n = 1, int_n = 1, nmi_n = 1;
  logic cfg_rising_edge = 0, cfg_skip_refresh = 0, cfg_use_status = 0;
  logic [15:0] trig_addr = '0, trig_addr_mask = '0;
  logic [7:0]  trig_stat = '0, trig_stat_mask = '0;
  logic [8:0]  post_count = '0;
  logic arm = 0;
  logic armed, triggered, done;
  logic [8:0] wr_count;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  logic [8:0] mid_count, pre_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_state_capture #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .m1_n(m1_n),
    .busreq_n(busreq_n), .halt_n(halt_n), .int_n(int_n), .nmi_n(nmi_n),
    .cfg_rising_edge(cfg_rising_edge), .cfg_skip_refresh(cfg_skip_refresh),
    .cfg_use_status(cfg_use_status), .trig_addr(trig_addr),
    .trig_addr_mask(trig_addr_mask), .trig_stat(trig_stat),
    .trig_stat_mask(trig_stat_mask), .post_count(post_count), .arm(arm),
    .armed(armed), .triggered(triggered), .done(done), .wr_count(wr_count),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input int kind, input bit rising);
    logic [7:0] s = 8'hF0;
    if (kind != 0) s[3] = 1'b1;
    if (kind != 5) s[2] = 1'b1;
    if (rising || !(kind == 3 || kind == 4)) s[1] = 1'b1;
    if (kind == 2 || kind == 4) s[0] = 1'b1;
    return s;
  endfunction

  task automatic bus_cycle(input int kind, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_count = wr_count;
    bus_addr = a; bus_data = d;
    wr_n   = !(kind == 2 || kind == 4);
    m1_n   = !(kind == 0);
    rfsh_n = !(kind == 5);
    repeat (2) @(negedge clk);
    if (kind == 3 || kind == 4) iorq_n = 0; else mreq_n = 0;
    repeat (6) @(negedge clk);
    mid_count = wr_count;
    mreq_n = 1; iorq_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
    m1_n = 1; rfsh_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_arm(input logic [8:0] pc);
    @(negedge clk);
    post_count = pc; arm = 1;
    @(negedge clk);
    arm = 0;
    @(negedge clk);
  endtask

  task automatic rd_word(input int idx, output logic [31:0] w);
    @(negedge clk);
    rd_addr = idx[7:0];
    @(negedge clk);
    w = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] exp_w [16];
    int n;
    bit trig;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 armed", armed, 0);
    chk("R1 triggered", triggered, 0);
    chk("R1 done", done, 0);
    chk("R1 wr_count", wr_count, 0);

    // table walk: address trigger 0x0100, refresh filtered, six words after trigger
    cfg_skip_refresh = 1; trig_addr = 16'h0100; trig_addr_mask = 16'hFFFF;
    do_arm(9'd6);
    chk("R11 armed after arm", armed, 1);
    n = 0; trig = 0;
    for (int i = 0; i < 11; i++) begin
      int kind;
      logic [15:0] a;
      logic [7:0] d;
      kind = int'(TBL[i][27:24]); a = TBL[i][23:8]; d = TBL[i][7:0];
      bus_cycle(kind, a, d);
      chk("R2 no capture at strobe assertion", mid_count, pre_count);
      if (kind != 5) begin
        if (!trig && a == 16'h0100) trig = 1;
        if (trig && n < 6) begin
          exp_w[n] = {a, d, exp_stat(kind, 0)};
          n++;
        end
      end
      if (i == 2) chk("R8 refresh at trigger address ignored", wr_count, 0);
    end
    chk("R10 count at post limit", wr_count, n);
    chk("R10 done", done, 1);
    chk("R8 triggered", triggered, 1);
    for (int i = 0; i < n; i++) begin
      rd_word(i, w);
      chk("R7 R5 R6 R4 stored word", w, exp_w[i]);
    end

    // refresh stored with filter off, halt active
    cfg_skip_refresh = 0; trig_addr_mask = 16'h0000; halt_n = 0;
    do_arm(9'd1);
    bus_cycle(5, 16'h007F, 8'h00);
    halt_n = 1;
    chk("R4 refresh kept when filter off", wr_count, 1);
    rd_word(0, w);
    chk("R5 refresh word with halt low", w, {16'h007F, 8'h00, 8'hBA});

    // status trigger: io cycles only
    cfg_use_status = 1; trig_stat = 8'h00; trig_stat_mask = 8'h02; cfg_skip_refresh = 1;
    do_arm(9'd2);
    bus_cycle(1, 16'h3000, 8'h01);
    chk("R9 mem cycle does not trigger", wr_count, 0);
    bus_cycle(3, 16'h0044, 8'h5A);
    bus_cycle(2, 16'h5000, 8'h77);
    chk("R9 count", wr_count, 2);
    rd_word(0, w);
    chk("R9 first word is io read", w, {16'h0044, 8'h5A, exp_stat(3, 0)});
    rd_word(1, w);
    chk("R12 second word", w, {16'h5000, 8'h77, exp_stat(2, 0)});
    cfg_use_status = 0;

    // assertion-edge mode
    cfg_rising_edge = 1;
    do_arm(9'd2);
    bus_cycle(4, 16'h00A5, 8'h3C);
    chk("R3 stored during strobe", mid_count, 1);
    bus_cycle(5, 16'h0003, 8'h00);
    chk("R3 R4 refresh skipped", wr_count, 1);
    bus_cycle(1, 16'h1234, 8'h56);
    chk("R3 done", done, 1);
    rd_word(0, w);
    chk("R3 io write word", w, {16'h00A5, 8'h3C, exp_stat(4, 1)});
    rd_word(1, w);
    chk("R3 mem read word", w, {16'h1234, 8'h56, exp_stat(1, 1)});
    cfg_rising_edge = 0;

    // full depth
    do_arm(9'd0);
    for (int i = 0; i < DEPTH + 2; i++) bus_cycle(1, 16'(i), 8'(i * 3));
    chk("R10 full depth count", wr_count, DEPTH);
    chk("R10 full depth done", done, 1);
    rd_word(0, w);
    chk("R12 word 0", w, {16'h0000, 8'h00, exp_stat(1, 0)});
    rd_word(DEPTH - 1, w);
    chk("R12 last word", w, {16'(DEPTH - 1), 8'((DEPTH - 1) * 3), exp_stat(1, 0)});

    // re-arm
    do_arm(9'd4);
    chk("R11 count cleared", wr_count, 0);
    chk("R11 done cleared", done, 0);
    chk("R11 triggered cleared", triggered, 0);
    chk("R11 armed", armed, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule